// File: doc/BRIEF.md
# Shared System Bus Controller

This block joins two bus masters to a memory module and an I/O module over one set of shared address, data and command lines. A master raises its request line and waits for its grant. The granted master's address, write data and command strobes are the only values that reach the shared lines. The lines of any master without a grant are forced to zero before they are merged.

The most significant address bit selects the target module. The remaining low bits select a word inside the memory, or a register port inside the I/O module. Each target accepts only its own pair of read and write strobes. It answers a valid command with a one-cycle transfer acknowledge. A watchdog on the shared lines raises an error to the owning master when a command gets no answer. This covers a strobe aimed at the wrong address space and an illegal strobe pattern. Reset clears the grant, both targets' storage and the watchdog.

Top module: `sysbus_fabric`

## Requirements
- R1: While reset is asserted and after it is released, both grants, both acknowledges and both error flags are 0. Every memory word and I/O port reads back 0 until it is written.
- R2: Arbitration is by fixed priority. With no current owner, the grant goes to the lowest-numbered master that is requesting. The grant appears at the first clock edge after the request is seen.
- R3: An owner keeps its grant as long as its own request stays high, even when master 0 requests in the meantime.
- R4: When the owner drops its request, the grant moves at the next clock edge to the highest-priority master still requesting, or to nobody.
- R5: At most one grant is high at any time. Strobes, address and data from a master without a grant reach no target: they give that master no acknowledge and change no stored value.
- R6: Address bit 7 set to 0 selects the 128-word memory, indexed by address bits 6:0. Address bit 7 set to 1 selects the I/O module, whose 8 ports are indexed by address bits 2:0, with the remaining bits ignored.
- R7: The strobe vector has 4 bits: bit 0 is memory read, bit 1 is memory write, bit 2 is I/O read and bit 3 is I/O write. A write stores the data word at the selected location. A read returns the stored word.
- R8: A valid command is acknowledged one clock edge after it first appears on the shared lines. The acknowledge lasts one cycle, and read data is valid on the master's read data port during that cycle.
- R9: A memory strobe aimed at an I/O address, or an I/O strobe aimed at a memory address, produces no acknowledge and changes no stored value.
- R10: If a strobe stays active with no acknowledge, the owner's error flag rises at the 8th clock edge after the strobe first appears. It stays high until the strobe is dropped and never coincides with an acknowledge.
- R11: A strobe vector with more than one bit set is ignored by both targets. It is then handled like R9 and ends in the R10 error.
- R12: A master's read data port is 0 whenever no read command is being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every transfer |
| rst_n | input | 1 | Active-low reset for all modules |
| m0_req | input | 1 | Master 0 bus request |
| m0_strb | input | 4 | Master 0 command strobes |
| m0_addr | input | 8 | Master 0 address |
| m0_wdata | input | 8 | Master 0 write data |
| m0_gnt | output | 1 | Master 0 bus grant |
| m0_ack | output | 1 | Transfer acknowledge to master 0 |
| m0_err | output | 1 | No-answer error to master 0 |
| m0_rdata | output | 8 | Read data to master 0 |
| m1_req | input | 1 | Master 1 bus request |
| m1_strb | input | 4 | Master 1 command strobes |
| m1_addr | input | 8 | Master 1 address |
| m1_wdata | input | 8 | Master 1 write data |
| m1_gnt | output | 1 | Master 1 bus grant |
| m1_ack | output | 1 | Transfer acknowledge to master 1 |
| m1_err | output | 1 | No-answer error to master 1 |
| m1_rdata | output | 8 | Read data to master 1 |

## Verification
The bench targets the following corner cases:
- Simultaneous requests and a master 0 request that arrives while master 1 owns the bus. A priority arbiter that pre-empts would hand the grant to master 0 in the middle of a transfer.
- A write attempted by the master that lacks the grant. A mux that leaks the lines of the master without a grant would corrupt memory.
- Strobes that cross address spaces and strobe vectors with several bits set, checked for silence and for an error exactly 8 cycles later. A loose decode would acknowledge these commands or store their data, and an off-by-one counter would flag the error a cycle early or late.
- The read data port between transfers, which must be zero. Data left enabled outside a read would show up there.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
   localparam int STRB_W   = 4;
   localparam int STB_MRD  = 0;
   localparam int STB_MWR  = 1;
   localparam int STB_IORD = 2;
   localparam int STB_IOWR = 3;
endpackage

// File: rtl/sysbus_arb.sv
module sysbus_arb #(
   parameter int NM = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NM-1:0] req,
   output logic [NM-1:0] gnt
);
   if (NM < 2) begin : g_bad_nm
      $error("sysbus_arb: NM must be at least 2");
   end

   logic [NM-1:0] gnt_q, gnt_d, pick;
   logic          keep;

   always_comb begin
      pick = '0;
      for (int i = NM - 1; i >= 0; i--) begin
         if (req[i]) begin
            pick    = '0;
            pick[i] = 1'b1;
         end
      end
      keep  = |(gnt_q & req);
      gnt_d = keep ? gnt_q : pick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt_q <= '0;
      else        gnt_q <= gnt_d;
   end

   assign gnt = gnt_q;

   // R5
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q));

   // R2
   prio_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req[0] && !(|(gnt_q & req))) |=> gnt_q[0]);

   for (genvar i = 0; i < NM; i++) begin : g_own
      // R3
      hold_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt_q[i] && req[i]) |=> gnt_q[i]);
      // R2
      gnt_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gnt_q[i]) |-> $past(req[i]));
   end
endmodule

// File: rtl/sysbus_target.sv
module sysbus_target
   import sysbus_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 8,
   parameter bit IO_SPACE = 1'b0,
   parameter int DEPTH    = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STRB_W-1:0] strb,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   output logic              ack
);
   localparam int IW     = $clog2(DEPTH);
   localparam int RD_BIT = IO_SPACE ? STB_IORD : STB_MRD;
   localparam int WR_BIT = IO_SPACE ? STB_IOWR : STB_MWR;

   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("sysbus_target: DEPTH must be a power of two of at least 2");
   end
   if (IW > AW - 1) begin : g_bad_iw
      $error("sysbus_target: DEPTH exceeds the space below the select bit");
   end

   logic          sel, lone, rd, wr, ack_q;
   logic [IW-1:0] idx;
   logic [DW-1:0] store [DEPTH];

   assign sel  = (addr[AW-1] == IO_SPACE);
   assign lone = $onehot(strb);
   assign rd   = sel && lone && strb[RD_BIT];
   assign wr   = sel && lone && strb[WR_BIT];
   assign idx  = addr[IW-1:0];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      store[w] <= '0;
         else if (wr && idx == IW'(w))    store[w] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= (rd || wr) && !ack_q;
   end

   assign rdata = rd ? store[idx] : '0;
   assign ack   = ack_q;

   // R8
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R9
   ack_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(sel && lone));
endmodule

// File: rtl/sysbus_tmo.sv
module sysbus_tmo #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic ack,
   output logic err
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("sysbus_tmo: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (!active || ack)       cnt <= '0;
      else if (cnt != CW'(LIMIT))    cnt <= cnt + 1'b1;
   end

   assign err = active && (cnt == CW'(LIMIT));

   // R10
   err_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !ack);

   // R10
   err_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(active));
endmodule

// File: rtl/sysbus_fabric.sv
module sysbus_fabric
   import sysbus_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 8,
   parameter int IO_PORTS = 8,
   parameter int TMO_CYC  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m0_req,
   input  logic [STRB_W-1:0] m0_strb,
   input  logic [AW-1:0]     m0_addr,
   input  logic [DW-1:0]     m0_wdata,
   output logic              m0_gnt,
   output logic              m0_ack,
   output logic              m0_err,
   output logic [DW-1:0]     m0_rdata,
   input  logic              m1_req,
   input  logic [STRB_W-1:0] m1_strb,
   input  logic [AW-1:0]     m1_addr,
   input  logic [DW-1:0]     m1_wdata,
   output logic              m1_gnt,
   output logic              m1_ack,
   output logic              m1_err,
   output logic [DW-1:0]     m1_rdata
);
   localparam int NM        = 2;
   localparam int MEM_WORDS = 2 ** (AW - 1);

   if (AW < 3) begin : g_bad_aw
      $error("sysbus_fabric: AW must be at least 3");
   end
   if (IO_PORTS > MEM_WORDS) begin : g_bad_io
      $error("sysbus_fabric: IO_PORTS exceeds the I/O address space");
   end

   logic [NM-1:0]     req, gnt;
   logic [STRB_W-1:0] strb_a  [NM];
   logic [AW-1:0]     addr_a  [NM];
   logic [DW-1:0]     wdata_a [NM];

   assign req        = {m1_req, m0_req};
   assign strb_a[0]  = m0_strb;
   assign strb_a[1]  = m1_strb;
   assign addr_a[0]  = m0_addr;
   assign addr_a[1]  = m1_addr;
   assign wdata_a[0] = m0_wdata;
   assign wdata_a[1] = m1_wdata;

   sysbus_arb #(.NM(NM)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .gnt   (gnt)
   );

   logic [STRB_W-1:0] bus_strb;
   logic [AW-1:0]     bus_addr;
   logic [DW-1:0]     bus_wdata, bus_rdata, mem_rdata, io_rdata;
   logic              mem_ack, io_ack, bus_ack, bus_err;

   always_comb begin
      bus_strb  = '0;
      bus_addr  = '0;
      bus_wdata = '0;
      for (int i = 0; i < NM; i++) begin
         bus_strb  |= strb_a[i]  & {STRB_W{gnt[i]}};
         bus_addr  |= addr_a[i]  & {AW{gnt[i]}};
         bus_wdata |= wdata_a[i] & {DW{gnt[i]}};
      end
   end

   sysbus_target #(.AW(AW), .DW(DW), .IO_SPACE(1'b0), .DEPTH(MEM_WORDS)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .strb  (bus_strb),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .rdata (mem_rdata),
      .ack   (mem_ack)
   );

   sysbus_target #(.AW(AW), .DW(DW), .IO_SPACE(1'b1), .DEPTH(IO_PORTS)) u_io (
      .clk   (clk),
      .rst_n (rst_n),
      .strb  (bus_strb),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .rdata (io_rdata),
      .ack   (io_ack)
   );

   assign bus_rdata = mem_rdata | io_rdata;
   assign bus_ack   = mem_ack | io_ack;

   sysbus_tmo #(.LIMIT(TMO_CYC)) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (|bus_strb),
      .ack    (bus_ack),
      .err    (bus_err)
   );

   assign m0_gnt   = gnt[0];
   assign m1_gnt   = gnt[1];
   assign m0_ack   = bus_ack & gnt[0];
   assign m1_ack   = bus_ack & gnt[1];
   assign m0_err   = bus_err & gnt[0];
   assign m1_err   = bus_err & gnt[1];
   assign m0_rdata = bus_rdata & {DW{gnt[0]}};
   assign m1_rdata = bus_rdata & {DW{gnt[1]}};

   // R6
   ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_ack && io_ack));

   // R12
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata != '0) |-> (bus_strb[STB_MRD] || bus_strb[STB_IORD]));
endmodule

// File: tb/sysbus_fabric_test.sv
module sysbus_fabric_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m0_req = 0, m1_req = 0;
   logic [3:0] m0_strb = 0, m1_strb = 0;
   logic [7:0] m0_addr = 0, m1_addr = 0, m0_wdata = 0, m1_wdata = 0;
   logic       m0_gnt, m1_gnt, m0_ack, m1_ack, m0_err, m1_err;
   logic [7:0] m0_rdata, m1_rdata;

   int checks = 0;
   int fails  = 0;
   logic [7:0] ref_mem [128];
   logic [7:0] ref_io  [8];

   always #(CLK_PERIOD / 2) clk = ~clk;

   sysbus_fabric uut (
      .clk(clk), .rst_n(rst_n),
      .m0_req(m0_req), .m0_strb(m0_strb), .m0_addr(m0_addr), .m0_wdata(m0_wdata),
      .m0_gnt(m0_gnt), .m0_ack(m0_ack), .m0_err(m0_err), .m0_rdata(m0_rdata),
      .m1_req(m1_req), .m1_strb(m1_strb), .m1_addr(m1_addr), .m1_wdata(m1_wdata),
      .m1_gnt(m1_gnt), .m1_ack(m1_ack), .m1_err(m1_err), .m1_rdata(m1_rdata)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic get_ack(input int m);
      return (m == 0) ? m0_ack : m1_ack;
   endfunction
   function automatic logic get_err(input int m);
      return (m == 0) ? m0_err : m1_err;
   endfunction
   function automatic logic get_gnt(input int m);
      return (m == 0) ? m0_gnt : m1_gnt;
   endfunction
   function automatic logic [7:0] get_rdata(input int m);
      return (m == 0) ? m0_rdata : m1_rdata;
   endfunction

   // expected legality from R6, R7, R9, R11
   function automatic bit legal_cmd(input logic [3:0] s, input logic [7:0] a);
      if (!$onehot(s)) return 1'b0;
      if (a[7]) return s[2] || s[3];
      return s[0] || s[1];
   endfunction

   task automatic drive(input int m, input logic [3:0] s, input logic [7:0] a, input logic [7:0] d);
      if (m == 0) begin m0_strb = s; m0_addr = a; m0_wdata = d; end
      else        begin m1_strb = s; m1_addr = a; m1_wdata = d; end
   endtask

   task automatic set_req(input int m, input logic v);
      if (m == 0) m0_req = v; else m1_req = v;
   endtask

   // full transfer by a granted master, checked against the reference model
   task automatic xfer(input int m, input logic [3:0] s, input logic [7:0] a, input logic [7:0] d);
      bit   got_ack = 0, got_err = 0, ok_legal;
      int   cyc = 0;
      logic [7:0] rd = 0, exp_rd = 0;
      ok_legal = legal_cmd(s, a);
      if (a[7]) exp_rd = ref_io[a[2:0]]; else exp_rd = ref_mem[a[6:0]];
      drive(m, s, a, d);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         cyc++;
         if (get_ack(m)) begin got_ack = 1; rd = get_rdata(m); break; end
         if (get_err(m)) begin got_err = 1; break; end
      end
      drive(m, 4'b0, 8'h00, 8'h00);
      if (ok_legal) begin
         // R8 acknowledge one edge after the strobe
         check(got_ack && cyc == 1, "R8 ack timing", cyc, 1);
         if (s[0] || s[2])
            check(rd == exp_rd, "R7 read data", rd, exp_rd);
         else
            check(rd == 8'h00, "R12 rdata zero on write", rd, 0);
         if (s[1]) ref_mem[a[6:0]] = d;
         if (s[3]) ref_io[a[2:0]]  = d;
      end else begin
         // R9 / R11 silent, then R10 error at the 8th edge
         check(!got_ack, "R9 no ack on bad command", got_ack, 0);
         check(got_err && cyc == 8, "R10 timeout cycle", cyc, 8);
      end
      @(negedge clk);
      // R8 pulse ends, R12 idle data is zero, R10 error cleared
      check(!get_ack(m) && !get_err(m), "R8 ack one cycle", {get_ack(m), get_err(m)}, 0);
      check(get_rdata(m) == 8'h00, "R12 idle rdata", get_rdata(m), 0);
   endtask

   task automatic acquire(input int m);
      set_req(m, 1'b1);
      @(negedge clk);
      check(get_gnt(m) == 1'b1 && get_gnt(1 - m) == 1'b0, "R2 grant after request", get_gnt(m), 1);
   endtask

   task automatic release_bus(input int m);
      set_req(m, 1'b0);
      @(negedge clk);
      check(get_gnt(m) == 1'b0, "R4 grant released", get_gnt(m), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
      for (int i = 0; i < 8; i++)   ref_io[i]  = 8'h00;

      repeat (3) @(negedge clk);
      // R1 state during reset
      check(!m0_gnt && !m1_gnt && !m0_ack && !m1_ack, "R1 reset outputs", {m0_gnt, m1_gnt, m0_ack, m1_ack}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!m0_err && !m1_err && m0_rdata == 0 && m1_rdata == 0, "R1 after reset", {m0_err, m1_err}, 0);

      // R1 memory and I/O start at zero
      acquire(0);
      xfer(0, 4'b0001, 8'h05, 8'h00);
      xfer(0, 4'b0100, 8'h83, 8'h00);
      release_bus(0);

      // R2 simultaneous requests, master 0 wins
      m0_req = 1; m1_req = 1;
      @(negedge clk);
      check(m0_gnt && !m1_gnt, "R2 priority", {m1_gnt, m0_gnt}, 1);
      // R4 handover to the remaining requester
      m0_req = 0;
      @(negedge clk);
      check(!m0_gnt && m1_gnt, "R4 handover", {m1_gnt, m0_gnt}, 2);
      // R3 owner keeps grant while master 0 requests
      m0_req = 1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(m1_gnt && !m0_gnt, "R3 hold grant", {m1_gnt, m0_gnt}, 2);
      end
      xfer(1, 4'b0010, 8'h10, 8'hA5);
      check(m1_gnt && !m0_gnt, "R3 hold across transfer", {m1_gnt, m0_gnt}, 2);
      m1_req = 0;
      @(negedge clk);
      check(m0_gnt && !m1_gnt, "R4 grant to waiting master", {m1_gnt, m0_gnt}, 1);

      // R5 master 1 drives a write without a grant
      drive(1, 4'b0010, 8'h10, 8'h3C);
      repeat (3) begin
         @(negedge clk);
         check(!m1_ack && !m0_ack && !m0_err, "R5 ungranted ignored", {m1_ack, m0_ack}, 0);
      end
      drive(1, 4'b0000, 8'h00, 8'h00);
      xfer(0, 4'b0001, 8'h10, 8'h00);   // R5 stored value must still be A5

      // R6 I/O aliasing on bits 2:0 and top-bit decode
      xfer(0, 4'b1000, 8'hF9, 8'h77);
      xfer(0, 4'b0100, 8'h81, 8'h00);
      xfer(0, 4'b0001, 8'h79, 8'h00);
      // R9 crossed spaces and R11 multi-bit strobe
      xfer(0, 4'b0010, 8'h85, 8'hEE);
      xfer(0, 4'b1000, 8'h05, 8'hEE);
      xfer(0, 4'b0011, 8'h05, 8'hEE);
      xfer(0, 4'b0001, 8'h05, 8'h00);
      xfer(0, 4'b0100, 8'h85, 8'h00);
      release_bus(0);
      @(negedge clk);

      // R7 constrained random mix
      for (int t = 0; t < 250; t++) begin
         int m, pick;
         logic [3:0] s;
         logic [7:0] a;
         m    = int'($urandom % 2);
         pick = int'($urandom % 12);
         a    = 8'($urandom);
         if (pick < 10) s = 4'b0001 << (pick % 4);
         else           s = (pick == 10) ? 4'b0101 : 4'b1010;
         if (pick < 10 && ($urandom % 4) != 0) a[7] = (s[2] || s[3]);
         acquire(m);
         xfer(m, s, a, 8'($urandom));
         release_bus(m);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule